// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Controller

This block gathers fault and event sources into a bank of status registers (two registers of eight bits by default) and drives a single active-low interrupt request line from them. Each status bit has its own enable bit. An enable bit decides only whether its status bit can pull the line low. The status bit itself is always recorded.

Sources arrive in two forms. One-cycle event pulses cover end of conversion, hot and cool. Level fault indications stay high while the fault is present. A level fault sets its status bit on its rising edge. A free-running counter also re-samples all levels once per period, so a fault that is still present after the host has cleared its bit comes back within a bounded time. The host bus logic reports a register read with a strobe and the register index, and that read clears the register.

One status bit can be marked as the automatic-acquisition end-of-conversion flag. While automatic mode is selected, this bit clears itself a fixed number of cycles after it was set. The interrupt line therefore pulses low for that short time and the host does not have to read the register.

Top module: `irq_ctl_top`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit becomes 0 and `irq_n_o` becomes 1.
- R2: An `event_i[k]` pulse sampled at an edge sets `stat_o[k]` at that edge. Bit k belongs to register k/8, bit position k%8. No other status bit changes.
- R3: A rising edge on `fault_lvl_i[k]` sets `stat_o[k]` at the first edge where the new level is sampled.
- R4: `irq_n_o` is 0 one cycle after any status bit is 1 together with its `en_i` bit, and 1 one cycle after no such pair exists. A cleared `en_i` bit leaves `stat_o` unchanged.
- R5: A read strobe with index r clears every bit of register r at that edge, that is, `stat_o[8r+7:8r]`. Other registers keep their values.
- R6: When a source sets a bit in the same cycle as a read or an automatic clear of that bit, the set wins and the bit stays 1.
- R7: If `fault_lvl_i[k]` is still high after its bit was cleared, `stat_o[k]` is set again within RESAMPLE_CYC cycles (16 by default). Once the level is low, a cleared bit stays 0.
- R8: With `auto_acq_i` high, an event on bit AUTO_BIT (8 by default, register 1 bit 0) keeps `stat_o[AUTO_BIT]` at 1 for exactly STRETCH_CYC cycles (6 by default), and then the bit clears itself. Other bits are never cleared automatically.
- R9: With `auto_acq_i` low, the AUTO_BIT status bit behaves like every other bit and stays set until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_lvl_i | input | 16 | Level fault indications, one per status bit |
| event_i | input | 16 | One-cycle event pulses, one per status bit |
| rd_stb_i | input | 1 | Status register read strobe |
| rd_idx_i | input | 1 | Index of the register being read |
| en_i | input | 16 | Enable bits, one per status bit |
| auto_acq_i | input | 1 | Automatic-acquisition mode select |
| stat_o | output | 16 | Status registers, register r at bits 8r+7..8r |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk`, and that `event_i` bits are true one-cycle pulses rather than held levels. They also assume that `rd_idx_i` names an existing register whenever the strobe is high. The stimulus meets these by driving every input one time unit after a rising edge. It raises each event for exactly one cycle and reads only registers 0 and 1. Level faults are held for many counter periods, so the resampling bound is exercised at arbitrary counter phases.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  // width of an index that selects one of n items (at least one bit)
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a counter that must hold the value n
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/irq_lvl_sampler.sv
module irq_lvl_sampler
  import irq_ctl_pkg::*;
#(
  parameter int N      = 16,
  parameter int PERIOD = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] set_o
);
  localparam int CW = cnt_width(PERIOD);

  logic [CW-1:0] cnt_q;
  logic [N-1:0]  lvl_q;
  logic          tick;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      lvl_q <= lvl_i;
    end
  end

  // new fault edge, or periodic re-sample of a persisting level
  assign set_o = lvl_i & (~lvl_q | {N{tick}});

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0)); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(PERIOD)); // R7

endmodule

// File: rtl/irq_stretch.sv
module irq_stretch
  import irq_ctl_pkg::*;
#(
  parameter int STRETCH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic expire_o
);
  localparam int CW = cnt_width(STRETCH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(STRETCH);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == CW'(1)) && !start_i;

  AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(STRETCH)); // R8

  AST_STRETCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == CW'(STRETCH))); // R8

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic [W-1:0] auto_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~({W{clr_i}} | auto_clr_i)) | set_i;
  end

  assign q_o = q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i))); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i == '0) |=> (q == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && set_i == '0 && auto_clr_i == '0) |=> $stable(q)); // R2

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int NUM_REGS     = 2,
  parameter int RESAMPLE_CYC = 16,
  parameter int STRETCH_CYC  = 6,
  parameter int AUTO_BIT     = 8,
  localparam int N           = REG_W * NUM_REGS,
  localparam int IDX_W       = sel_width(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     fault_lvl_i,
  input  logic [N-1:0]     event_i,
  input  logic             rd_stb_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [N-1:0]     en_i,
  input  logic             auto_acq_i,
  output logic [N-1:0]     stat_o,
  output logic             irq_n_o
);
  logic [N-1:0] lvl_set;
  logic [N-1:0] set_all;
  logic [N-1:0] auto_clr;
  logic         auto_start;
  logic         auto_expire;
  logic         irq_n_q;

  irq_lvl_sampler #(.N(N), .PERIOD(RESAMPLE_CYC)) i_sampler (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (fault_lvl_i),
    .set_o (lvl_set)
  );

  assign set_all    = event_i | lvl_set;
  assign auto_start = auto_acq_i && event_i[AUTO_BIT];

  irq_stretch #(.STRETCH(STRETCH_CYC)) i_stretch (
    .clk      (clk),
    .rst      (rst),
    .start_i  (auto_start),
    .expire_o (auto_expire)
  );

  always_comb begin
    auto_clr           = '0;
    auto_clr[AUTO_BIT] = auto_expire;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic clr;
    assign clr = rd_stb_i && (rd_idx_i == IDX_W'(g));

    irq_status_reg #(.W(REG_W)) i_reg (
      .clk        (clk),
      .rst        (rst),
      .set_i      (set_all[g*REG_W +: REG_W]),
      .clr_i      (clr),
      .auto_clr_i (auto_clr[g*REG_W +: REG_W]),
      .q_o        (stat_o[g*REG_W +: REG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(stat_o & en_i);
  end

  assign irq_n_o = irq_n_q;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (stat_o == '0 && irq_n_o)); // R1

  AST_LOW_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    !irq_n_o |-> $past(stat_o != '0)); // R4

  AST_QUIET_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (stat_o == '0) |=> irq_n_o); // R4

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (event_i != '0) |=> ((stat_o & $past(event_i)) == $past(event_i))); // R2

endmodule

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;
  localparam int N = 16;
  localparam int P = 16;
  localparam int S = 6;
  localparam int AB = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] fault_lvl = '0;
  logic [N-1:0] evt = '0;
  logic         rd_stb = 1'b0;
  logic [0:0]   rd_idx = '0;
  logic [N-1:0] en = '1;
  logic         auto_acq = 1'b0;
  logic [N-1:0] stat;
  logic         irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ctl_top i_irq_ctl_top (
    .clk(clk), .rst(rst), .fault_lvl_i(fault_lvl), .event_i(evt),
    .rd_stb_i(rd_stb), .rd_idx_i(rd_idx), .en_i(en), .auto_acq_i(auto_acq),
    .stat_o(stat), .irq_n_o(irq_n)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int k);
    evt = N'(1) << k; step(); evt = '0;
  endtask

  task automatic rd(input int r);
    rd_stb = 1'b1; rd_idx = 1'(r); step(); rd_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    step(); step(); step();
    chk(stat, '0, "R1 status after reset");
    chk(N'(irq_n), N'(1), "R1 line after reset");
    rst = 1'b0;

    // R2 / R4 / R5 sweep over every bit
    for (int i = 0; i < N; i++) begin
      pulse(i);
      chk(stat, N'(1) << i, "R2 event latch");
      step();
      chk(N'(irq_n), N'(0), "R4 enabled bit drives line");
      rd(i / 8);
      chk(stat, '0, "R5 read clears");
      step();
      chk(N'(irq_n), N'(1), "R4 line released");
    end

    // R4 masking sweep: mask only the set bit
    for (int i = 0; i < N; i++) begin
      en = ~(N'(1) << i);
      pulse(i); step();
      chk(stat, N'(1) << i, "R4 masked bit still latched");
      chk(N'(irq_n), N'(1), "R4 masked bit leaves line high");
      en = '1; step();
      chk(N'(irq_n), N'(0), "R4 unmask drives line");
      rd(i / 8); step();
    end

    // R5: a read touches only its own register
    evt = (N'(1) << 3) | (N'(1) << 11); step(); evt = '0;
    rd(0);
    chk(stat, N'(1) << 11, "R5 register 1 untouched");
    rd(1);
    chk(stat, '0, "R5 register 1 cleared");

    // R6: set in same cycle as read
    pulse(2);
    evt = (N'(1) << 5) | (N'(1) << 2); rd_stb = 1'b1; rd_idx = 1'b0; step();
    evt = '0; rd_stb = 1'b0;
    chk(stat, (N'(1) << 5) | (N'(1) << 2), "R6 set beats read");
    rd(0);

    // R3 / R7 level faults
    for (int i = 0; i < N; i++) begin
      fault_lvl = N'(1) << i; step();
      chk(stat, N'(1) << i, "R3 level edge latch");
      for (int w = 0; w < i % 5; w++) step();
      rd(i / 8);
      cnt = 0;
      while (stat[i] !== 1'b1 && cnt <= P + 2) begin step(); cnt++; end
      chk(N'(cnt <= P), N'(1), "R7 persisting fault re-sets in time");
      fault_lvl = '0; step();
      rd(i / 8);
      for (int w = 0; w < P + 2; w++) step();
      chk(stat, '0, "R7 removed fault stays clear");
    end

    // R8 automatic end-of-conversion stretch
    auto_acq = 1'b1;
    pulse(AB);
    chk(stat, N'(1) << AB, "R8 auto bit set");
    cnt = 1;
    step();
    chk(N'(irq_n), N'(0), "R8 line pulled low during stretch");
    while (stat[AB] === 1'b1 && cnt < S + 4) begin cnt++; step(); end
    chk(N'(cnt), N'(S), "R8 stretch length");
    pulse(AB + 1);
    for (int w = 0; w < S + 4; w++) step();
    chk(stat, N'(1) << (AB + 1), "R8 non-auto bit not self-cleared");
    rd(1);
    auto_acq = 1'b0;

    // R9 auto bit without automatic mode
    pulse(AB);
    for (int w = 0; w < S + 4; w++) step();
    chk(stat, N'(1) << AB, "R9 auto bit held without mode");
    rd(1);
    chk(stat, '0, "R9 read clears auto bit");

    finish_run();
  end
endmodule